// File: doc/BRIEF.md
# Fractional M-over-N Clock Divider

This block produces an output rate of M/N of its clock's rate, averaged over N clock cycles. A phase accumulator adds M on every cycle. Whenever the sum reaches N, it takes N off and marks a wrap. Each wrap gives one output period. A second output is a shaped clock level, and the duty value sets how long it stays high within each period. Both outputs are plain signals in the clock domain, so the block can drive a clock-enable or feed a glitch-free gating cell.

The three ratio fields arrive in the encoding that the control registers use:
- The multiplier is plain.
- The span field holds the bitwise complement of (N − M), masked to FIELD_W bits.
- The duty field holds the complement of the duty value D, also masked.

The block decodes these fields itself. Writing the duty field as the complement of N gives a half-period duty.

A mode input chooses between pass-through and fractional operation. Fractional operation runs only when the configuration can actually divide. A new configuration is taken only at a wrap, so an output period is never cut short. The block has no data stream, so there is no valid/ready handshake; every pin is plain control or status.

Top module: `frac_mnd_divider`

## Requirements
- R1: While rst_n is low, tick_o and clk_o are both 0.
- R2: When the active configuration is pass-through, tick_o is 1 on every cycle after the first clock edge out of reset, and clk_o equals tick_o.
- R3: The effective divisor is N = ((~span_inv_i) & (2^FIELD_W − 1)) + mul_i, computed FIELD_W+1 bits wide.
- R4: With a fractional configuration held stable, any window of N consecutive cycles contains exactly M cycles with tick_o = 1.
- R5: Fractional operation is selected only when mode_i ≠ 0, mul_i ≠ 0 and mul_i < N. Every other case, including M = N and M = 0, runs as pass-through.
- R6: Let the phase after a loading wrap start at 0 and advance by M modulo N on each cycle. In fractional operation, clk_o is 1 exactly when 2 × phase < T.
- R7: The threshold is T = max(2M, min(Draw, 2(N − M))), where Draw = (~duty_inv_i) & (2^FIELD_W − 1).
- R8: New input values take effect only at a wrap. Until then, tick_o and clk_o follow the previously active configuration.
- R9: At a wrap where the decoded configuration differs from the active one, the phase restarts at 0. At a wrap with an unchanged configuration, the remainder (sum − N) is kept.
- R10: When 2M ≤ N, every output period between two ticks contains at least one high and one low cycle of clk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; every rate is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 selects pass-through; any nonzero value requests fractional operation |
| mul_i | input | FIELD_W | Multiplier M |
| span_inv_i | input | FIELD_W | Complement of (N − M) |
| duty_inv_i | input | FIELD_W | Complement of the duty value D |
| tick_o | output | 1 | One-cycle mark for each output period (each wrap) |
| clk_o | output | 1 | Shaped output level |

## Verification
A wrong phase value shows on clk_o in the cycle it is wrong, because the level is a direct compare of the phase against the threshold. The same fault shifts tick_o by the end of the current period. A divisor that is decoded wrong, or a remainder that is lost, changes the number of ticks in a window of N cycles, so it shows within one full period. A configuration loaded at the wrong moment changes the spacing of the very next tick. A missed restart shows as a first period after reconfiguration that is shorter than ceil(N/M) cycles.

// File: rtl/mnd_pkg.sv
package mnd_pkg;
  parameter int unsigned MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_PASS = '0;
endpackage

// File: rtl/mnd_cfg_decode.sv
module mnd_cfg_decode
  import mnd_pkg::*;
#(
  parameter int unsigned FIELD_W = 9,
  localparam int unsigned NW = FIELD_W + 1,
  localparam int unsigned TW = FIELD_W + 2
) (
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [FIELD_W-1:0] mul_i,
  input  logic [FIELD_W-1:0] span_inv_i,
  input  logic [FIELD_W-1:0] duty_inv_i,
  output logic               run_o,
  output logic [FIELD_W-1:0] m_o,
  output logic [NW-1:0]      n_o,
  output logic [TW-1:0]      thr_o
);
  logic [NW-1:0] n_full;
  logic [NW-1:0] m_wide;
  logic [TW-1:0] floor_v, ceil_v, raw_v, capped, thr_c;
  logic          ok;

  assign m_wide  = {1'b0, mul_i};
  assign n_full  = {1'b0, ~span_inv_i} + m_wide;
  assign ok      = (mode_i != MODE_PASS) && (mul_i != '0) && (m_wide < n_full);

  // duty window: at least one high step, at least one low step
  assign floor_v = {1'b0, mul_i, 1'b0};
  assign ceil_v  = {n_full - m_wide, 1'b0};
  assign raw_v   = {2'b00, ~duty_inv_i};
  assign capped  = (raw_v > ceil_v) ? ceil_v : raw_v;
  assign thr_c   = (capped < floor_v) ? floor_v : capped;

  // non-running configurations collapse to one canonical value
  assign run_o = ok;
  assign m_o   = ok ? mul_i  : '0;
  assign n_o   = ok ? n_full : '0;
  assign thr_o = ok ? thr_c  : '0;
endmodule

// File: rtl/mnd_phase_acc.sv
module mnd_phase_acc #(
  parameter int unsigned FIELD_W = 9,
  localparam int unsigned NW = FIELD_W + 1,
  localparam int unsigned TW = FIELD_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dec_run_i,
  input  logic [FIELD_W-1:0] dec_m_i,
  input  logic [NW-1:0]      dec_n_i,
  input  logic [TW-1:0]      dec_thr_i,
  output logic               act_run_o,
  output logic [FIELD_W-1:0] act_m_o,
  output logic [NW-1:0]      act_n_o,
  output logic [TW-1:0]      act_thr_o,
  output logic [NW-1:0]      phase_o,
  output logic               tick_o,
  output logic               wrap_o
);
  logic               run_q;
  logic [FIELD_W-1:0] m_q;
  logic [NW-1:0]      n_q;
  logic [TW-1:0]      thr_q;
  logic [NW-1:0]      phase_q;
  logic               tick_q;
  logic [TW-1:0]      sum, rem;
  logic               wrap, changed;
  logic [NW-1:0]      phase_d;

  assign sum     = {1'b0, phase_q} + {2'b00, m_q};
  assign wrap    = !run_q || (sum >= {1'b0, n_q});
  assign changed = (dec_run_i != run_q) || (dec_m_i != m_q) ||
                   (dec_n_i != n_q) || (dec_thr_i != thr_q);
  assign rem     = run_q ? (sum - {1'b0, n_q}) : '0;

  always_comb begin
    if (!wrap)        phase_d = sum[NW-1:0];
    else if (changed) phase_d = '0;
    else              phase_d = rem[NW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      m_q     <= '0;
      n_q     <= '0;
      thr_q   <= '0;
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tick_q  <= wrap;
      if (wrap) begin
        run_q <= dec_run_i;
        m_q   <= dec_m_i;
        n_q   <= dec_n_i;
        thr_q <= dec_thr_i;
      end
    end
  end

  assign act_run_o = run_q;
  assign act_m_o   = m_q;
  assign act_n_o   = n_q;
  assign act_thr_o = thr_q;
  assign phase_o   = phase_q;
  assign tick_o    = tick_q;
  assign wrap_o    = wrap;
endmodule

// File: rtl/mnd_duty_shaper.sv
module mnd_duty_shaper #(
  parameter int unsigned FIELD_W = 9,
  localparam int unsigned NW = FIELD_W + 1,
  localparam int unsigned TW = FIELD_W + 2
) (
  input  logic          run_i,
  input  logic [NW-1:0] phase_i,
  input  logic [TW-1:0] thr_i,
  input  logic          tick_i,
  output logic          level_o
);
  logic [TW-1:0] phase2;
  assign phase2  = {phase_i, 1'b0};
  assign level_o = run_i ? (phase2 < thr_i) : tick_i;
endmodule

// File: rtl/frac_mnd_divider.sv
module frac_mnd_divider
  import mnd_pkg::*;
#(
  parameter int unsigned FIELD_W = 9,
  localparam int unsigned NW = FIELD_W + 1,
  localparam int unsigned TW = FIELD_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [FIELD_W-1:0] mul_i,
  input  logic [FIELD_W-1:0] span_inv_i,
  input  logic [FIELD_W-1:0] duty_inv_i,
  output logic               tick_o,
  output logic               clk_o
);
  logic               dec_run;
  logic [FIELD_W-1:0] dec_m;
  logic [NW-1:0]      dec_n;
  logic [TW-1:0]      dec_thr;
  logic               act_run;
  logic [FIELD_W-1:0] act_m;
  logic [NW-1:0]      act_n;
  logic [TW-1:0]      act_thr;
  logic [NW-1:0]      phase;
  logic               tick;
  logic               wrap;

  mnd_cfg_decode #(.FIELD_W(FIELD_W)) dec_u (
    .mode_i(mode_i), .mul_i(mul_i), .span_inv_i(span_inv_i),
    .duty_inv_i(duty_inv_i), .run_o(dec_run), .m_o(dec_m),
    .n_o(dec_n), .thr_o(dec_thr)
  );

  mnd_phase_acc #(.FIELD_W(FIELD_W)) acc_u (
    .clk(clk), .rst_n(rst_n),
    .dec_run_i(dec_run), .dec_m_i(dec_m), .dec_n_i(dec_n), .dec_thr_i(dec_thr),
    .act_run_o(act_run), .act_m_o(act_m), .act_n_o(act_n), .act_thr_o(act_thr),
    .phase_o(phase), .tick_o(tick), .wrap_o(wrap)
  );

  mnd_duty_shaper #(.FIELD_W(FIELD_W)) shp_u (
    .run_i(act_run), .phase_i(phase), .thr_i(act_thr),
    .tick_i(tick), .level_o(clk_o)
  );

  assign tick_o = tick;
endmodule

// File: rtl/frac_mnd_divider_chk.sv
module frac_mnd_divider_chk #(
  parameter int unsigned FIELD_W = 9,
  localparam int unsigned NW = FIELD_W + 1,
  localparam int unsigned TW = FIELD_W + 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_o,
  input logic               clk_o,
  input logic               act_run,
  input logic [FIELD_W-1:0] act_m,
  input logic [NW-1:0]      act_n,
  input logic [TW-1:0]      act_thr,
  input logic [NW-1:0]      phase,
  input logic               wrap
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!tick_o && !clk_o));

  // R2
  pass_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_run |=> tick_o);

  // R4
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_run |-> (phase < act_n));

  // R7
  thr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_run |-> (act_thr >= {1'b0, act_m, 1'b0}));

  // R6
  phase0_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_run && phase == '0) |-> clk_o);

  // R8
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_run) && $stable(act_m) && $stable(act_n) && $stable(act_thr)));
endmodule

bind frac_mnd_divider frac_mnd_divider_chk #(.FIELD_W(FIELD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_o(tick_o), .clk_o(clk_o),
  .act_run(act_run), .act_m(act_m), .act_n(act_n), .act_thr(act_thr),
  .phase(phase), .wrap(wrap)
);

// File: tb/frac_mnd_divider_tb_top.sv
module frac_mnd_divider_tb_top;
  localparam int W = 9;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]   mode = '0;
  logic [W-1:0] mul = '0, ninv = '0, dinv = '0;
  logic tick, clko;

  always #10 clk = ~clk;

  frac_mnd_divider #(.FIELD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .mul_i(mul),
    .span_inv_i(ninv), .duty_inv_i(dinv), .tick_o(tick), .clk_o(clko)
  );

  int total = 0, bad = 0;
  bit cmp_en = 0, done = 0;

  // behavioural reference state
  int ar = 0, am = 0, an = 0, at = 0, ph = 0, mt = 0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ref_decode(output int r, output int m, output int n, output int t);
    int nn, lo, hi, raw;
    nn  = ((~int'(ninv)) & MASK) + int'(mul);
    r   = (mode != 0 && mul != 0 && int'(mul) < nn) ? 1 : 0;
    lo  = 2 * int'(mul);
    hi  = 2 * (nn - int'(mul));
    raw = (~int'(dinv)) & MASK;
    t   = (raw > hi) ? hi : raw;
    if (t < lo) t = lo;
    m = int'(mul); n = nn;
    if (r == 0) begin m = 0; n = 0; t = 0; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar = 0; am = 0; an = 0; at = 0; ph = 0; mt = 0;
    end else begin
      int r, m, n, t, s;
      ref_decode(r, m, n, t);
      s = ph + am;
      if (ar == 0 || s >= an) begin
        mt = 1;
        if (r != ar || m != am || n != an || t != at) ph = 0;
        else ph = (ar != 0) ? s - an : 0;
        ar = r; am = m; an = n; at = t;
      end else begin
        mt = 0;
        ph = s;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      int ec;
      ec = (ar != 0) ? ((2 * ph < at) ? 1 : 0) : mt;
      check("R4 tick_o vs model", int'(tick), mt);
      check("R6 clk_o vs model", int'(clko), ec);
    end
  end

  task automatic setcfg(int md, int m, int n, int d);
    mode = 2'(md);
    mul  = W'(m);
    ninv = W'(~(n - m));
    dinv = W'(~d);
  endtask

  task automatic wait_tick();
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (tick) break;
    end
  endtask

  task automatic observe(int cyc, output int ticks, output int highs, output int badp);
    bit hi_seen, lo_seen, started;
    ticks = 0; highs = 0; badp = 0;
    hi_seen = 0; lo_seen = 0; started = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (tick) begin
        ticks++;
        if (started && !(hi_seen && lo_seen)) badp++;
        started = 1; hi_seen = 0; lo_seen = 0;
      end
      if (clko) begin highs++; hi_seen = 1; end
      else lo_seen = 1;
    end
  endtask

  initial begin
    int tk, hs, bp, k;
    setcfg(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 tick_o in reset", int'(tick), 0);
    check("R1 clk_o in reset", int'(clko), 0);
    rst_n = 1'b1;
    cmp_en = 1;
    repeat (2) @(negedge clk);
    check("R2 tick_o pass-through", int'(tick), 1);
    check("R2 clk_o pass-through", int'(clko), 1);

    setcfg(2, 3, 8, 8); wait_tick(); wait_tick();
    observe(80, tk, hs, bp);
    check("R4 ticks 3/8 over 80", tk, 30);
    check("R10 periods 3/8", bp, 0);

    setcfg(1, 2, 9, 9); wait_tick(); wait_tick();
    observe(90, tk, hs, bp);
    check("R4 ticks 2/9 over 90", tk, 20);
    check("R10 periods 2/9", bp, 0);

    setcfg(3, 4, 9, 9); wait_tick(); wait_tick();
    observe(90, tk, hs, bp);
    check("R4 ticks 4/9 over 90", tk, 40);
    check("R10 periods 4/9", bp, 0);

    setcfg(2, 119, 359, 359); wait_tick(); wait_tick();
    observe(718, tk, hs, bp);
    check("R3 ticks 119/359 over 718", tk, 238);
    check("R10 periods 119/359", bp, 0);

    setcfg(2, 1, 1, 1); wait_tick(); wait_tick();
    observe(10, tk, hs, bp);
    check("R5 M equal N runs as pass-through", tk, 10);
    setcfg(2, 0, 8, 8); wait_tick(); wait_tick();
    observe(10, tk, hs, bp);
    check("R5 M zero runs as pass-through", tk, 10);
    setcfg(0, 3, 8, 8); wait_tick(); wait_tick();
    observe(10, tk, hs, bp);
    check("R5 mode zero runs as pass-through", tk, 10);

    setcfg(2, 1, 8, 0); wait_tick(); wait_tick();
    observe(8, tk, hs, bp);
    check("R7 highs with duty floor", hs, 1);
    setcfg(2, 1, 8, MASK); wait_tick(); wait_tick();
    observe(8, tk, hs, bp);
    check("R7 highs with duty ceiling", hs, 7);
    setcfg(2, 1, 8, 8); wait_tick(); wait_tick();
    observe(8, tk, hs, bp);
    check("R6 highs at half duty", hs, 4);

    // R8: switch to pass-through right after a wrap of the 1/8 run
    wait_tick();
    setcfg(0, 0, 0, 0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      check("R8 old ratio holds until wrap", int'(tick), 0);
    end
    @(negedge clk);
    check("R8 load at wrap", int'(tick), 1);
    @(negedge clk);
    check("R8 pass-through after load", int'(tick), 1);

    // R9: reconfigure 3/8 -> 3/7, phase restarts at zero
    setcfg(2, 3, 8, 8); wait_tick(); wait_tick();
    repeat (5) @(negedge clk);
    wait_tick();
    setcfg(2, 3, 7, 7);
    wait_tick();
    check("R9 clk_o high at restarted phase", int'(clko), 1);
    k = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      k++;
      if (tick) break;
    end
    check("R9 first period after restart", k, 3);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule